// File: doc/BRIEF.md
# Two-Level Hardware Page Table Walker

This block resolves a translation miss entirely in hardware. When the translation buffer misses, it hands the faulting virtual address to the walker. The walker then reads a two-tier hierarchical page table starting at the top tier, using a base address held in a root-table register. It returns the final mapping on a refill output so the buffer can install it. No software handler runs and no interrupt is taken. Every table access uses a physical address, so the walk never needs a translation of its own.

Each walk is a fixed chain of steps, one state per step:

1. Extract the top-tier index from the address.
2. Add that index to the root base.
3. Load the top-tier entry.
4. Extract the second-tier index.
5. Add it to the frame base carried by the entry just loaded.
6. Load the leaf entry.
7. Present the leaf mapping.

Only the leaf mapping ever leaves the block; the top-tier entry is used internally as a pointer. An entry with its valid bit clear ends the walk with a fault pulse that names the tier, and no refill follows.

The memory side is a single read port. The request and address are held until the memory grants them. The read data arrives with a valid strobe, either in the grant cycle or any later cycle.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `miss_ready` is 1 and `mem_req`, `refill_valid` and `fault_valid` are 0.
- R2: A miss is accepted only on a cycle where `miss_valid` and `miss_ready` are both 1. `miss_ready` drops for the whole walk. A miss presented during a walk starts no extra read and does not alter the walk in progress.
- R3: The first read address is `root_base + miss_vaddr[31:22]*4`. The second read address is `{E1[31:12], 12'h000} + miss_vaddr[21:12]*4`, where E1 is the first entry read. In every entry, bit 0 is the valid bit and bits [31:12] hold the frame number.
- R4: A walk whose first entry is valid performs exactly two reads, top tier first and leaf second.
- R5: A walk succeeds when both entries are valid. Success raises `refill_valid` for exactly one cycle, with `refill_vpn = miss_vaddr[31:12]` and `refill_pte` equal to the leaf entry. The top-tier entry never appears on the refill output.
- R6: With a memory that grants and answers in the request cycle, `refill_valid` is high in walk cycle 7. Walk cycle 1 is the first cycle after the acceptance edge.
- R7: If the first entry has bit 0 clear, `fault_valid` pulses for one cycle with `fault_level = 0`. Only one read occurs and there is no refill. With a zero-latency memory the pulse falls in walk cycle 4.
- R8: If the leaf entry has bit 0 clear, `fault_valid` pulses for one cycle with `fault_level = 1` after two reads, and there is no refill. With a zero-latency memory the pulse falls in walk cycle 7.
- R9: `mem_req` stays high with an unchanged `mem_addr` until `mem_gnt`. After a grant, the walker waits for `mem_rvalid`, which may arrive in the grant cycle or later.
- R10: The cycle after a refill or fault pulse, `miss_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | Translation miss request |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_ready | output | 1 | Walker idle and able to accept a miss |
| root_base | input | 32 | Physical base address of the top-tier table |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Physical address of the entry to read |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (table entry) |
| refill_valid | output | 1 | One-cycle pulse: leaf mapping ready for insertion |
| refill_vpn | output | 20 | Virtual page number of the mapping |
| refill_pte | output | 32 | Leaf entry to insert |
| fault_valid | output | 1 | One-cycle pulse: walk ended on an invalid entry |
| fault_level | output | 1 | Tier of the invalid entry: 0 top, 1 leaf |

## Verification
The in-RTL properties watch several rules on every cycle:

- the request hold with a stable address while the grant is missing;
- the single-cycle shape and mutual exclusion of the refill and fault pulses;
- the number of grants counted at each outcome (two at a refill, one at a top-tier fault);
- that a valid leaf entry is the only thing refilled;
- the return to ready after each outcome.

Whether the two read addresses combine the right index bits with the right base, the exact seven-cycle length, and that a miss offered mid-walk is ignored can only be shown by the bench's scenarios. The bench compares these against its own model of the table memory, across varied grant and response latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MASK_R,
    ST_ADD_R,
    ST_LOAD_R,
    ST_MASK_L,
    ST_ADD_L,
    ST_LOAD_L,
    ST_FILL,
    ST_FAULT
  } walk_st_e;

  localparam int ENTRY_VLD_BIT = 0;
endpackage

// File: rtl/ptw_load_port.sv
module ptw_load_port (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic gnt,
  input  logic rvalid,
  output logic req,
  output logic done
);
  logic issued_q, issued_d;

  assign req  = active && !issued_q;
  assign done = active && rvalid && (issued_q || gnt);

  always_comb begin
    issued_d = issued_q;
    if (done)
      issued_d = 1'b0;
    else if (req && gnt)
      issued_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      issued_q <= 1'b0;
    else
      issued_q <= issued_d;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> req);
endmodule

// File: rtl/ptw_addr_path.sv
module ptw_addr_path #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10,
  parameter int ENTRY_B    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [VA_W-1:0]            vaddr_in,
  input  logic [PA_W-1:0]            rbase_in,
  input  logic                       mask_en,
  input  logic                       add_en,
  input  logic                       level,
  input  logic                       root_cap,
  input  logic                       leaf_cap,
  input  logic [PA_W-1:0]            rdata,
  output logic [PA_W-1:0]            entry_addr,
  output logic [VA_W-PAGE_SHIFT-1:0] vpn,
  output logic [PA_W-1:0]            leaf_entry
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int PFN_W = PA_W - PAGE_SHIFT;
  localparam int SZ_SH = $clog2(ENTRY_B);
  localparam int PAD_W = PA_W - IDX_W - SZ_SH;

  logic [VPN_W-1:0] vpn_q;
  logic [PA_W-1:0]  rbase_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic [PFN_W-1:0] lbase_q;
  logic [PA_W-1:0]  leaf_q;
  logic [PA_W-1:0]  base_sel;
  logic [PA_W-1:0]  offs;

  always_comb begin
    idx_d = level ? vpn_q[IDX_W-1:0] : vpn_q[2*IDX_W-1:IDX_W];
  end

  always_comb begin
    base_sel = level ? {lbase_q, {PAGE_SHIFT{1'b0}}} : rbase_q;
    offs     = {{PAD_W{1'b0}}, idx_q, {SZ_SH{1'b0}}};
    addr_d   = base_sel + offs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q   <= '0;
      rbase_q <= '0;
    end else if (cap_en) begin
      vpn_q   <= vaddr_in[VA_W-1:PAGE_SHIFT];
      rbase_q <= rbase_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (mask_en)
      idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (add_en)
      addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lbase_q <= '0;
    else if (root_cap)
      lbase_q <= rdata[PA_W-1:PAGE_SHIFT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      leaf_q <= '0;
    else if (leaf_cap)
      leaf_q <= rdata;
  end

  assign entry_addr = addr_q;
  assign vpn        = vpn_q;
  assign leaf_entry = leaf_q;

  // R3
  addr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> (addr_q[SZ_SH-1:0] == base_sel[SZ_SH-1:0]));
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic load_done,
  input  logic entry_vld,
  output logic miss_ready,
  output logic cap_en,
  output logic mask_en,
  output logic add_en,
  output logic level,
  output logic load_act,
  output logic root_cap,
  output logic leaf_cap,
  output logic refill_valid,
  output logic fault_valid,
  output logic fault_level
);
  walk_st_e st_q, st_d;
  logic     flvl_q, flvl_d;

  always_comb begin
    st_d   = st_q;
    flvl_d = flvl_q;
    unique case (st_q)
      ST_IDLE:   if (miss_valid) st_d = ST_MASK_R;
      ST_MASK_R: st_d = ST_ADD_R;
      ST_ADD_R:  st_d = ST_LOAD_R;
      ST_LOAD_R: if (load_done) begin
                   if (entry_vld) st_d = ST_MASK_L;
                   else begin
                     st_d   = ST_FAULT;
                     flvl_d = 1'b0;
                   end
                 end
      ST_MASK_L: st_d = ST_ADD_L;
      ST_ADD_L:  st_d = ST_LOAD_L;
      ST_LOAD_L: if (load_done) begin
                   if (entry_vld) st_d = ST_FILL;
                   else begin
                     st_d   = ST_FAULT;
                     flvl_d = 1'b1;
                   end
                 end
      ST_FILL:   st_d = ST_IDLE;
      ST_FAULT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      flvl_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flvl_q <= flvl_d;
    end
  end

  assign miss_ready   = (st_q == ST_IDLE);
  assign cap_en       = (st_q == ST_IDLE) && miss_valid;
  assign mask_en      = (st_q == ST_MASK_R) || (st_q == ST_MASK_L);
  assign add_en       = (st_q == ST_ADD_R) || (st_q == ST_ADD_L);
  assign level        = (st_q == ST_MASK_L) || (st_q == ST_ADD_L);
  assign load_act     = (st_q == ST_LOAD_R) || (st_q == ST_LOAD_L);
  assign root_cap     = (st_q == ST_LOAD_R) && load_done && entry_vld;
  assign leaf_cap     = (st_q == ST_LOAD_L) && load_done;
  assign refill_valid = (st_q == ST_FILL);
  assign fault_valid  = (st_q == ST_FAULT);
  assign fault_level  = flvl_q;

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);
  // R5
  refill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |=> !refill_valid);
  // R7
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);
  // R10
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid || fault_valid) |=> miss_ready);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10,
  parameter int ENTRY_B    = 4,
  parameter int VPN_W      = VA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [VA_W-1:0]  miss_vaddr,
  output logic             miss_ready,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [PA_W-1:0]  mem_rdata,
  output logic             refill_valid,
  output logic [VPN_W-1:0] refill_vpn,
  output logic [PA_W-1:0]  refill_pte,
  output logic             fault_valid,
  output logic             fault_level
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic cap_en, mask_en, add_en, level, load_act, root_cap, leaf_cap, load_done;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .miss_valid   (miss_valid),
    .load_done    (load_done),
    .entry_vld    (mem_rdata[ptw_pkg::ENTRY_VLD_BIT]),
    .miss_ready   (miss_ready),
    .cap_en       (cap_en),
    .mask_en      (mask_en),
    .add_en       (add_en),
    .level        (level),
    .load_act     (load_act),
    .root_cap     (root_cap),
    .leaf_cap     (leaf_cap),
    .refill_valid (refill_valid),
    .fault_valid  (fault_valid),
    .fault_level  (fault_level)
  );

  ptw_addr_path #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .IDX_W      (IDX_W),
    .ENTRY_B    (ENTRY_B)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .cap_en     (cap_en),
    .vaddr_in   (miss_vaddr),
    .rbase_in   (root_base),
    .mask_en    (mask_en),
    .add_en     (add_en),
    .level      (level),
    .root_cap   (root_cap),
    .leaf_cap   (leaf_cap),
    .rdata      (mem_rdata),
    .entry_addr (mem_addr),
    .vpn        (refill_vpn),
    .leaf_entry (refill_pte)
  );

  ptw_load_port u_port (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .active (load_act),
    .gnt    (mem_gnt),
    .rvalid (mem_rvalid),
    .req    (mem_req),
    .done   (load_done)
  );

  // grant counter used only by the properties below
  logic [1:0] gnt_cnt_q;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)
      gnt_cnt_q <= 2'd0;
    else if (miss_valid && miss_ready)
      gnt_cnt_q <= 2'd0;
    else if (mem_req && mem_gnt && gnt_cnt_q != 2'd3)
      gnt_cnt_q <= gnt_cnt_q + 2'd1;
  end

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req && !mem_gnt) |=> $stable(mem_addr));
  // R4
  two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    refill_valid |-> (gnt_cnt_q == 2'd2));
  // R7
  one_read_fault_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fault_valid && !fault_level) |-> (gnt_cnt_q == 2'd1));
  // R5
  leaf_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    refill_valid |-> (refill_pte[0] && !fault_valid));
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic [31:0] miss_vaddr;
  logic        miss_ready;
  logic [31:0] root_base;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        refill_valid;
  logic [19:0] refill_vpn;
  logic [31:0] refill_pte;
  logic        fault_valid;
  logic        fault_level;

  always #5 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_ready(miss_ready), .root_base(root_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .refill_valid(refill_valid), .refill_vpn(refill_vpn),
    .refill_pte(refill_pte), .fault_valid(fault_valid), .fault_level(fault_level)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // table memory model: contents are a hash of the address, bit 0 forced by mode
  // mode 0: natural, 1: both valid, 2: first invalid, 3: first valid/leaf invalid
  function automatic logic [31:0] mem_val(input logic [31:0] a, input int n,
                                          input int mode);
    logic [31:0] x;
    x = a * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    case (mode)
      1: x[0] = 1'b1;
      2: x[0] = (n != 0);
      3: x[0] = (n == 0);
      default: ;
    endcase
    return x;
  endfunction

  int          cfg_g, cfg_l, cur_mode;
  int          gcnt, pcnt, pn, rd_cnt;
  bit          pend;
  logic [31:0] paddr;
  logic [31:0] rd_addr [2];

  always @(negedge clk) begin
    cyc++;
    mem_gnt    = 1'b0;
    mem_rvalid = 1'b0;
    if (pend) begin
      if (pcnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_val(paddr, pn, cur_mode);
        pend       = 1'b0;
      end else pcnt--;
    end else if (mem_req) begin
      if (gcnt > 0) gcnt--;
      else begin
        mem_gnt = 1'b1;
        if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
        pn    = rd_cnt;
        paddr = mem_addr;
        rd_cnt++;
        gcnt  = cfg_g;
        if (cfg_l == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_val(paddr, pn, cur_mode);
        end else begin
          pend = 1'b1;
          pcnt = cfg_l - 1;
        end
      end
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [31:0] rb,
                          input int mode, input int g, input int l, input bit poke);
    logic [31:0] ra, rp, la, lp;
    int k, reads_before;
    bit got, ev_ref, ev_flt, ev_lvl;
    logic [19:0] ev_vpn;
    logic [31:0] ev_pte;
    @(negedge clk); #1;
    chk(miss_ready === 1'b1, "R2 ready while idle", {31'd0, miss_ready}, 32'd1);
    cfg_g = g; cfg_l = l; cur_mode = mode; gcnt = g; rd_cnt = 0; pend = 1'b0;
    miss_valid = 1'b1; miss_vaddr = va; root_base = rb;
    k = 0; got = 1'b0;
    ev_ref = 0; ev_flt = 0; ev_lvl = 0; ev_vpn = '0; ev_pte = '0;
    while (!got && k < 400) begin
      @(negedge clk); #1;
      k++;
      if (k == 1) miss_valid = 1'b0;
      if (poke && k == 2) begin miss_valid = 1'b1; miss_vaddr = ~va; end
      if (poke && k == 3) miss_valid = 1'b0;
      if (refill_valid || fault_valid) begin
        got = 1'b1; ev_ref = refill_valid; ev_flt = fault_valid;
        ev_lvl = fault_level; ev_vpn = refill_vpn; ev_pte = refill_pte;
      end
    end
    chk(got, "R2 walk completes", 32'(k), 32'd0);
    ra = rb + {20'd0, va[31:22], 2'b00};
    rp = mem_val(ra, 0, mode);
    chk(rd_addr[0] === ra, "R3 first read address", rd_addr[0], ra);
    if (!rp[0]) begin
      chk(ev_flt && !ev_ref && !ev_lvl, "R7 top-tier fault", {29'd0, ev_flt, ev_ref, ev_lvl}, 32'h4);
      chk(rd_cnt == 1, "R7 single read", 32'(rd_cnt), 32'd1);
      if (g == 0 && l == 0) chk(k == 4, "R7 fault cycle", 32'(k), 32'd4);
    end else begin
      la = {rp[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
      lp = mem_val(la, 1, mode);
      chk(rd_cnt == 2, "R4 two reads", 32'(rd_cnt), 32'd2);
      chk(rd_addr[1] === la, "R3 second read address", rd_addr[1], la);
      if (!lp[0]) begin
        chk(ev_flt && !ev_ref && ev_lvl, "R8 leaf fault", {29'd0, ev_flt, ev_ref, ev_lvl}, 32'h5);
        if (g == 0 && l == 0) chk(k == 7, "R8 fault cycle", 32'(k), 32'd7);
      end else begin
        chk(ev_ref && !ev_flt, "R5 refill raised", {30'd0, ev_ref, ev_flt}, 32'h2);
        chk(ev_vpn === va[31:12], "R5 refill vpn", {12'd0, ev_vpn}, {12'd0, va[31:12]});
        chk(ev_pte === lp, "R5 refill leaf entry", ev_pte, lp);
        if (g == 0 && l == 0) chk(k == 7, "R6 seven-cycle walk", 32'(k), 32'd7);
      end
    end
    @(negedge clk); #1;
    chk(miss_ready === 1'b1, "R10 ready after outcome", {31'd0, miss_ready}, 32'd1);
    chk(!refill_valid && !fault_valid, "R5 single-cycle pulse",
        {30'd0, refill_valid, fault_valid}, 32'd0);
    if (poke) begin
      reads_before = rd_cnt;
      repeat (5) @(negedge clk);
      #1;
      chk(rd_cnt == reads_before && !mem_req, "R2 mid-walk miss ignored",
          32'(rd_cnt), 32'(reads_before));
    end
  endtask

  initial begin
    automatic int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst_n = 1'b0; miss_valid = 1'b0; miss_vaddr = '0; root_base = '0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    cfg_g = 0; cfg_l = 0; cur_mode = 1; gcnt = 0; pcnt = 0; pn = 0; rd_cnt = 0;
    pend = 1'b0; rd_addr[0] = '0; rd_addr[1] = '0; paddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(miss_ready === 1'b1, "R1 ready after reset", {31'd0, miss_ready}, 32'd1);
    chk(mem_req === 1'b0, "R1 no request after reset", {31'd0, mem_req}, 32'd0);
    chk(refill_valid === 1'b0, "R1 no refill after reset", {31'd0, refill_valid}, 32'd0);
    chk(fault_valid === 1'b0, "R1 no fault after reset", {31'd0, fault_valid}, 32'd0);

    run_walk(32'h1234_5678, 32'h0010_0000, 1, 0, 0, 1'b0); // R6 R4 R5
    run_walk(32'h89AB_CDEF, 32'h0020_0000, 2, 0, 0, 1'b0); // R7
    run_walk(32'h4567_1000, 32'h0030_0000, 3, 0, 0, 1'b0); // R8
    run_walk(32'hDEAD_B000, 32'h0040_0000, 1, 2, 3, 1'b1); // R9 R2
    run_walk(32'hFFFF_FFFF, 32'h0000_1000, 1, 0, 0, 1'b0); // R3 top indices
    run_walk(32'h0000_0000, 32'h7FFF_F000, 1, 1, 0, 1'b0); // R3 zero indices
    run_walk(32'h0040_2000, 32'h0050_0000, 2, 3, 2, 1'b1); // R7 with latency

    for (int i = 0; i < 60; i++) begin
      run_walk($urandom, {$urandom_range(0, 32'hF_FFFF), 12'h000},
               int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule